// File: doc/BRIEF.md
# I2C Serial Memory Slave Protocol Engine

This block is the protocol core of a small I2C serial memory. It runs on a fast system clock and receives the SCL and SDA levels already synchronized to that clock, together with one-cycle strobes for start and stop conditions found by a separate detector. It drives an open-drain enable for SDA: high means pull the line low. It recognizes its own address byte, keeps the word pointer that reads and writes share, and acknowledges or refuses each byte.

Each accepted write data byte goes out on a one-cycle strobe with its target address, to a page buffer outside the block. A stop that ends a transfer with accepted data raises a commit strobe, which starts the nonvolatile write cycle. Read data comes back combinationally from the array at the address the block presents. Two inputs refuse writes. A busy input (write cycle in progress) refuses every byte. A write-protect input refuses only data bytes.

The parameter `ADDR_W` sets the capacity, from 7 to 11 address bits. Any address bits above 8 are taken from the low pin-compare positions of the address byte, one 256-byte block per value. `PAGE_W` sets the page size.

Top module: `smem_i2c_slave`

## Requirements
- R1: An address byte is acknowledged only when its bits 7:4 are 1010 and each of its bits 3:1 that is not a block bit equals the matching pin (bit 3 with pin 2, bit 2 with pin 1, bit 1 with pin 0). Bit 0 is the direction: 1 reads, 0 writes.
- R2: With `ADDR_W` > 8, address-byte bits `ADDR_W-8`:1 are not compared with the pins. When a word-address byte is accepted, they become the top word-address bits. With the default `ADDR_W`=9, bit 1 is word-address bit 8.
- R3: Bytes are shifted MSB first. An accepted byte is acknowledged by pulling SDA low for the whole 9th SCL clock. The SDA enable rises only while SCL is low.
- R4: While busy is high, no byte is acknowledged, the address byte included. Once busy is low, an address byte is acknowledged again.
- R5: With write protect high, the address byte and the word-address byte are acknowledged. Data bytes are refused, no write strobe is issued, and no commit follows the stop.
- R6: Each accepted data byte is presented with the current pointer as its address. The pointer then increments within its page: the low `PAGE_W` bits wrap and the upper bits are kept. More bytes than one page overwrite earlier ones.
- R7: A stop raises the commit strobe for one cycle only if at least one data byte was accepted since the last start. A random-read setup write produces no commit.
- R8: A read that starts with a read address returns the byte at the pointer, which is the last accessed address plus one.
- R9: A write address, a word address, a repeated start and a read address return the byte at the newly loaded word address.
- R10: In a read, a master acknowledge yields the byte at pointer+1. The pointer wraps from the last array address to 0.
- R11: After a master non-acknowledge, the engine releases SDA and drives nothing until the next stop or start, whatever SCL does.
- R12: A start in any state abandons the transfer in progress and begins address reception. The pointer keeps its value.
- R13: After reset, the SDA enable, the write strobe and the commit strobe are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level (bus) |
| start_i | input | 1 | One-cycle start / repeated-start strobe |
| stop_i | input | 1 | One-cycle stop strobe |
| pins_i | input | 3 | Address select pins, index 2 is the highest |
| wp_i | input | 1 | Write protect |
| busy_i | input | 1 | Internal write cycle in progress |
| rd_data_i | input | 8 | Array byte at rd_addr_o |
| sda_oe_o | output | 1 | Pull SDA low when high |
| wr_valid_o | output | 1 | Accepted data byte strobe |
| wr_addr_o | output | ADDR_W | Address of the accepted byte |
| wr_data_o | output | 8 | Accepted data byte |
| wr_commit_o | output | 1 | Start nonvolatile write cycle |
| rd_addr_o | output | ADDR_W | Word pointer, read address |

## Verification
The bench writes 17 bytes into one page starting two bytes before the page end. A design that let the pointer carry into the next page would corrupt a neighbouring page, and the readback of the wrapped bytes would show it. A sequential read across the top address catches a pointer that saturates or skips address 0. A block-bit pair (0x0A5 against 0x1A5) shows whether address-byte bit 1 really reaches word-address bit 8. The write-protect and busy runs look at the ninth-clock level and the commit count, which shows a design that accepts protected data or acknowledges its address during a write cycle. A master NACK followed by further SCL clocks shows a design that keeps sending, and a start inside a word-address byte shows one that fails to abandon the transfer.

// File: rtl/smem_pkg.sv
package smem_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT_STOP
    } smem_state_e;

endpackage

// File: rtl/smem_scl_edge.sv
module smem_scl_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    output logic rise_o,
    output logic fall_o
);
    logic scl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scl_q <= 1'b1;
        else        scl_q <= scl_i;
    end

    assign rise_o = scl_i & ~scl_q;
    assign fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/smem_addr_dec.sv
module smem_addr_dec #(
    parameter int ADDR_W = 9
) (
    input  logic [6:0]       dev_bits_i,   // address byte bits 7:1
    input  logic [2:0]       pins_i,
    output logic             hit_o,
    output logic [((ADDR_W > 8) ? ADDR_W - 8 : 1) - 1:0] blk_o
);
    localparam int BLK_BITS = (ADDR_W > 8) ? ADDR_W - 8 : 0;
    localparam int BLK_W    = (BLK_BITS > 0) ? BLK_BITS : 1;

    logic miss;

    always_comb begin
        miss = (dev_bits_i[6:3] != 4'b1010);
        for (int i = 0; i < 3; i++) begin
            if (i >= BLK_BITS) miss = miss | (dev_bits_i[i] ^ pins_i[i]);
        end
    end

    assign hit_o = ~miss;

    generate
        if (BLK_BITS > 0) begin : g_blk
            assign blk_o = dev_bits_i[BLK_W-1:0];
        end else begin : g_noblk
            assign blk_o = '0;
        end
    endgenerate
endmodule

// File: rtl/smem_ptr_next.sv
module smem_ptr_next #(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 4
) (
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic [((ADDR_W > 8) ? ADDR_W - 8 : 1) - 1:0] blk_i,
    input  logic [7:0]        word_i,
    output logic [ADDR_W-1:0] page_inc_o,
    output logic [ADDR_W-1:0] full_inc_o,
    output logic [ADDR_W-1:0] load_o
);
    logic [PAGE_W-1:0] low_inc;

    assign low_inc    = ptr_i[PAGE_W-1:0] + 1'b1;
    assign page_inc_o = {ptr_i[ADDR_W-1:PAGE_W], low_inc};
    assign full_inc_o = ptr_i + 1'b1;

    generate
        if (ADDR_W > 8) begin : g_wide
            assign load_o = {blk_i, word_i};
        end else begin : g_narrow
            assign load_o = word_i[ADDR_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/smem_i2c_slave.sv
module smem_i2c_slave
    import smem_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [2:0]        pins_i,
    input  logic              wp_i,
    input  logic              busy_i,
    input  logic [7:0]        rd_data_i,
    output logic              sda_oe_o,
    output logic              wr_valid_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic              wr_commit_o,
    output logic [ADDR_W-1:0] rd_addr_o
);
    localparam int BLK_BITS = (ADDR_W > 8) ? ADDR_W - 8 : 0;
    localparam int BLK_W    = (BLK_BITS > 0) ? BLK_BITS : 1;

    typedef struct packed {
        smem_state_e       state;
        logic [3:0]        cnt;
        logic [7:0]        shreg;
        logic              ack;
        logic              rw;
        logic [BLK_W-1:0]  blk;
        logic [ADDR_W-1:0] ptr;
        logic              pending;
        logic              oe;
        logic              wr_valid;
        logic [ADDR_W-1:0] wr_addr;
        logic [7:0]        wr_data;
        logic              commit;
    } regs_t;

    regs_t r_q, r_d;

    logic              scl_rise, scl_fall;
    logic              dev_hit;
    logic [BLK_W-1:0]  dev_blk;
    logic [ADDR_W-1:0] ptr_page_inc, ptr_full_inc, ptr_load;
    logic              byte_done, ack_done, take;

    smem_scl_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_i),
        .rise_o (scl_rise),
        .fall_o (scl_fall)
    );

    smem_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .dev_bits_i (r_q.shreg[7:1]),
        .pins_i     (pins_i),
        .hit_o      (dev_hit),
        .blk_o      (dev_blk)
    );

    smem_ptr_next #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .ptr_i      (r_q.ptr),
        .blk_i      (r_q.blk),
        .word_i     (r_q.shreg),
        .page_inc_o (ptr_page_inc),
        .full_inc_o (ptr_full_inc),
        .load_o     (ptr_load)
    );

    assign byte_done = scl_fall && (r_q.cnt == 4'd8);
    assign ack_done  = scl_fall && (r_q.cnt == 4'd1);

    always_comb begin
        r_d          = r_q;
        r_d.wr_valid = 1'b0;
        r_d.commit   = 1'b0;
        take         = 1'b0;

        if (stop_i) begin
            r_d.state   = ST_IDLE;
            r_d.oe      = 1'b0;
            r_d.commit  = r_q.pending;
            r_d.pending = 1'b0;
            r_d.cnt     = '0;
        end else if (start_i) begin
            r_d.state   = ST_DEV;
            r_d.oe      = 1'b0;
            r_d.pending = 1'b0;
            r_d.cnt     = '0;
        end else begin
            case (r_q.state)
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        r_d.shreg = {r_q.shreg[6:0], sda_i};
                        r_d.cnt   = r_q.cnt + 4'd1;
                    end else if (byte_done) begin
                        r_d.cnt = '0;
                        unique case (r_q.state)
                            ST_DEV: begin
                                take      = dev_hit && !busy_i;
                                r_d.state = ST_DEV_ACK;
                                if (take) begin
                                    r_d.rw  = r_q.shreg[0];
                                    r_d.blk = dev_blk;
                                end
                            end
                            ST_WADDR: begin
                                take      = !busy_i;
                                r_d.state = ST_WADDR_ACK;
                                if (take) r_d.ptr = ptr_load;
                            end
                            default: begin
                                take      = !busy_i && !wp_i;
                                r_d.state = ST_WDATA_ACK;
                                if (take) begin
                                    r_d.wr_valid = 1'b1;
                                    r_d.wr_addr  = r_q.ptr;
                                    r_d.wr_data  = r_q.shreg;
                                    r_d.ptr      = ptr_page_inc;
                                    r_d.pending  = 1'b1;
                                end
                            end
                        endcase
                        r_d.ack = take;
                        r_d.oe  = take;
                    end
                end
                ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: begin
                    if (scl_rise) begin
                        r_d.cnt = 4'd1;
                    end else if (ack_done) begin
                        r_d.cnt = '0;
                        r_d.oe  = 1'b0;
                        if (!r_q.ack) begin
                            r_d.state = ST_WAIT_STOP;
                        end else if (r_q.state == ST_DEV_ACK) begin
                            if (r_q.rw) begin
                                r_d.state = ST_RDATA;
                                r_d.shreg = rd_data_i;
                                r_d.oe    = ~rd_data_i[7];
                            end else begin
                                r_d.state = ST_WADDR;
                            end
                        end else begin
                            r_d.state = ST_WDATA;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        r_d.cnt = r_q.cnt + 4'd1;
                    end else if (byte_done) begin
                        r_d.cnt   = '0;
                        r_d.oe    = 1'b0;
                        r_d.ptr   = ptr_full_inc;
                        r_d.state = ST_RACK;
                    end else if (scl_fall && r_q.cnt != 4'd0) begin
                        r_d.shreg = {r_q.shreg[6:0], 1'b0};
                        r_d.oe    = ~r_q.shreg[6];
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        r_d.cnt = 4'd1;
                        r_d.ack = ~sda_i;
                    end else if (ack_done) begin
                        r_d.cnt = '0;
                        if (r_q.ack) begin
                            r_d.state = ST_RDATA;
                            r_d.shreg = rd_data_i;
                            r_d.oe    = ~rd_data_i[7];
                        end else begin
                            r_d.state = ST_WAIT_STOP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe_o    = r_q.oe;
    assign wr_valid_o  = r_q.wr_valid;
    assign wr_addr_o   = r_q.wr_addr;
    assign wr_data_o   = r_q.wr_data;
    assign wr_commit_o = r_q.commit;
    assign rd_addr_o   = r_q.ptr;

    // R3: the SDA enable only rises while SCL is low
    a_r3_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_i);

    // R4: no acknowledge is started while busy
    a_r4_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe_o) && r_q.state != ST_RDATA) |-> !$past(busy_i));

    // R5: no data byte is accepted under write protect
    a_r5_wp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> !$past(wp_i));

    // R6: after each accepted byte the pointer sits at the next page slot
    a_r6_page_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> (rd_addr_o[PAGE_W-1:0] == PAGE_W'(wr_addr_o[PAGE_W-1:0] + 1'b1)
                        && rd_addr_o[ADDR_W-1:PAGE_W] == wr_addr_o[ADDR_W-1:PAGE_W]));

    // R7: a commit only follows a stop strobe
    a_r7_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit_o |-> $past(stop_i));

    // R11: SDA stays released while waiting for stop
    a_r11_released_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WAIT_STOP) |-> !sda_oe_o);
endmodule

// File: tb/smem_i2c_slave_tb.sv
module smem_i2c_slave_tb_top;
    localparam int ADDR_W = 9;
    localparam int PAGE_W = 4;
    localparam logic [2:0] PINS = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic master_low = 1'b0;
    logic start_s = 1'b0, stop_s = 1'b0;
    logic wp = 1'b0, busy = 1'b0;
    logic sda_bus;
    logic [7:0] rd_data;
    logic sda_oe, wr_valid, wr_commit;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [7:0] wr_data;

    logic [7:0] mem [0:(1<<ADDR_W)-1];
    int checks = 0, failures = 0, commits = 0;
    bit done = 0;

    always #5 clk = ~clk;

    assign sda_bus = ~(master_low | sda_oe);
    assign rd_data = mem[rd_addr];

    smem_i2c_slave #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .start_i(start_s), .stop_i(stop_s), .pins_i(PINS), .wp_i(wp),
        .busy_i(busy), .rd_data_i(rd_data), .sda_oe_o(sda_oe),
        .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .wr_commit_o(wr_commit), .rd_addr_o(rd_addr)
    );

    function automatic logic [7:0] init_val(int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    initial begin
        for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = init_val(i);
    end

    always @(posedge clk) begin
        if (wr_valid) mem[wr_addr] <= wr_data;
        if (wr_commit) commits <= commits + 1;
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_cycle(input logic drive_low, output logic sampled);
        master_low = drive_low;
        wait_clk(3);
        scl = 1'b1;
        wait_clk(3);
        sampled = sda_bus;
        wait_clk(2);
        scl = 1'b0;
        wait_clk(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cycle(~b[i], s);
        bit_cycle(1'b0, s);
        ack = ~s;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic mack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b0, s);
            d[i] = s;
        end
        bit_cycle(mack, s);
    endtask

    task automatic do_start();
        master_low = 1'b0;
        wait_clk(2);
        scl = 1'b1;
        wait_clk(2);
        master_low = 1'b1;
        start_s = 1'b1;
        wait_clk(1);
        start_s = 1'b0;
        wait_clk(2);
        scl = 1'b0;
        wait_clk(2);
    endtask

    task automatic do_stop();
        master_low = 1'b1;
        wait_clk(2);
        scl = 1'b1;
        wait_clk(2);
        master_low = 1'b0;
        stop_s = 1'b1;
        wait_clk(1);
        stop_s = 1'b0;
        wait_clk(4);
    endtask

    function automatic logic [7:0] dev(logic blk, logic rw);
        return {4'b1010, PINS[2:1], blk, rw};
    endfunction

    task automatic byte_write(input logic [8:0] a, input logic [7:0] d, output logic ok);
        logic k1, k2, k3;
        do_start();
        send_byte(dev(a[8], 1'b0), k1);
        send_byte(a[7:0], k2);
        send_byte(d, k3);
        do_stop();
        wait_clk(2);
        ok = k1 & k2 & k3;
    endtask

    task automatic rand_read(input logic [8:0] a, output logic [7:0] d, output logic ok);
        logic k1, k2, k3;
        do_start();
        send_byte(dev(a[8], 1'b0), k1);
        send_byte(a[7:0], k2);
        do_start();
        send_byte(dev(1'b0, 1'b1), k3);
        recv_byte(d, 1'b0);
        do_stop();
        ok = k1 & k2 & k3;
    endtask

    // table: {address[8:0], data[7:0]} written then read back (R6, R7, R9, R2)
    localparam int NVEC = 5;
    localparam logic [16:0] VEC [NVEC] = '{
        {9'h003, 8'h11}, {9'h0A5, 8'h22}, {9'h1A5, 8'h3C},
        {9'h140, 8'h5A}, {9'h0FF, 8'hC3}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic ok, k1, k2, k3, s;
        logic [7:0] d0, d1, d2;
        int c0, lows;

        wait_clk(4);
        // R13: reset state
        chk("R13 oe", sda_oe, 0);
        chk("R13 wr_valid", wr_valid, 0);
        chk("R13 commit", wr_commit, 0);
        rst_n = 1'b1;
        wait_clk(4);
        scl = 1'b0;
        wait_clk(2);

        // table walk: byte writes then random reads (R6, R7, R9)
        for (int v = 0; v < NVEC; v++) begin
            c0 = commits;
            byte_write(VEC[v][16:8], VEC[v][7:0], ok);
            chk("R3 write acks", ok, 1);
            chk("R7 one commit per write", commits - c0, 1);
            c0 = commits;
            rand_read(VEC[v][16:8], d0, ok);
            chk("R9 random read data", d0, VEC[v][7:0]);
            chk("R7 no commit on read setup", commits - c0, 0);
        end

        // R2: block bit separates 0x0A5 from 0x1A5
        rand_read(9'h0A5, d0, ok);
        chk("R2 low block", d0, 8'h22);
        rand_read(9'h1A5, d0, ok);
        chk("R2 high block", d0, 8'h3C);

        // R1: wrong identifier and wrong pin
        do_start();
        send_byte(8'b1011_1000, k1);
        do_stop();
        chk("R1 bad id nack", k1, 0);
        do_start();
        send_byte({4'b1010, 1'b0, PINS[1], 1'b0, 1'b0}, k1);
        do_stop();
        chk("R1 bad pin nack", k1, 0);

        // R4: busy refuses address, then polling succeeds
        busy = 1'b1;
        do_start();
        send_byte(dev(1'b0, 1'b0), k1);
        do_stop();
        chk("R4 busy nack", k1, 0);
        busy = 1'b0;
        c0 = commits;
        do_start();
        send_byte(dev(1'b0, 1'b0), k1);
        do_stop();
        chk("R4 poll ack", k1, 1);
        chk("R7 no commit without data", commits - c0, 0);

        // R5: write protect
        wp = 1'b1;
        c0 = commits;
        do_start();
        send_byte(dev(1'b0, 1'b0), k1);
        send_byte(8'h50, k2);
        send_byte(8'h77, k3);
        do_stop();
        wait_clk(2);
        wp = 1'b0;
        chk("R5 address ack", k1, 1);
        chk("R5 word ack", k2, 1);
        chk("R5 data nack", k3, 0);
        chk("R5 no commit", commits - c0, 0);
        rand_read(9'h050, d0, ok);
        chk("R5 unchanged", d0, init_val(9'h050));

        // R6: 17-byte page write starting at 0x1E wraps inside page 0x10..0x1F
        do_start();
        send_byte(dev(1'b0, 1'b0), k1);
        send_byte(8'h1E, k2);
        ok = k1 & k2;
        for (int k = 0; k < 17; k++) begin
            send_byte(8'(8'h80 + k), k3);
            ok = ok & k3;
        end
        do_stop();
        wait_clk(2);
        chk("R6 page acks", ok, 1);
        // R8: pointer now 0x1F
        do_start();
        send_byte(dev(1'b0, 1'b1), k1);
        recv_byte(d0, 1'b0);
        do_stop();
        chk("R8 current read", d0, 8'h81);
        rand_read(9'h01E, d0, ok);
        chk("R6 overwritten first slot", d0, 8'h90);
        rand_read(9'h010, d0, ok);
        chk("R6 wrapped slot", d0, 8'h82);
        rand_read(9'h020, d0, ok);
        chk("R6 next page untouched", d0, init_val(9'h020));

        // R10: sequential read across top address
        do_start();
        send_byte(dev(1'b1, 1'b0), k1);
        send_byte(8'hFE, k2);
        do_start();
        send_byte(dev(1'b0, 1'b1), k3);
        recv_byte(d0, 1'b1);
        recv_byte(d1, 1'b1);
        recv_byte(d2, 1'b0);
        // R11: more clocks after NACK, SDA must stay released
        lows = 0;
        for (int i = 0; i < 9; i++) begin
            bit_cycle(1'b0, s);
            if (!s) lows++;
        end
        do_stop();
        chk("R10 byte 0x1FE", d0, init_val(9'h1FE));
        chk("R10 byte 0x1FF", d1, init_val(9'h1FF));
        chk("R10 wrap to 0", d2, init_val(0));
        chk("R11 released after nack", lows, 0);

        // R12: start inside a word-address byte aborts; pointer unchanged (0x001)
        do_start();
        send_byte(dev(1'b0, 1'b0), k1);
        bit_cycle(1'b1, s);
        bit_cycle(1'b0, s);
        bit_cycle(1'b1, s);
        do_start();
        send_byte(dev(1'b0, 1'b1), k2);
        recv_byte(d0, 1'b0);
        do_stop();
        chk("R12 read ack after abort", k2, 1);
        chk("R12 pointer kept", d0, init_val(1));

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule